// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the seven status flags of an asynchronous serial port and runs the two-step sequences that software uses to clear them. The bus side gives it one-cycle strobes for a status read, a status write, a data read and a data write, and the block returns the status byte. The transmitter and receiver cores give it event pulses and levels: the transmit buffer has emptied, the transmitter has gone idle, a character has arrived (with its byte, noise and framing bits), the receive line level is idle, and the receiver wake-up bit is set. The block also holds the received character so that a data read returns it, and it keeps that character when an overrun occurs.

A flag is cleared in two steps. First a status read sees the flag set, which arms that flag's clear bit. Then a data access of the matching kind clears the armed flags: a data write clears the transmit flags and a data read clears the receive flags. A flag that sets after the status read is not armed, so it is still set after the access. The idle-line flag runs in a three-state machine. In HUNT it sets as soon as the line is idle and wake-up is off (HUNT to SET). In SET an armed data read clears it (SET to WAIT). In WAIT it stays clear until the line goes active (WAIT to HUNT). Reset enters HUNT. Two interrupt request outputs are the OR of the transmit flags and the OR of the receive-data flags.

Top module: `uart_flag_ctrl`

## Requirements
- R1: The status byte is {tdre, tc, rdrf, idle, ovr, noise, ferr, 0}: bit 7 transmit-buffer-empty, bit 6 transmit-complete, bit 5 receive-buffer-full, bit 4 idle-line, bit 3 overrun, bit 2 noise, bit 1 framing error, and bit 0 always 0. It reflects the registered flags in the same cycle.
- R2: After reset the status byte is 8'hC0, both interrupt outputs follow from that value (irq_tx=1, irq_rx=0), and the held receive byte is 0.
- R3: A tx_empty_evt pulse sets tdre at the next clock. A data write clears tdre if an earlier status read saw tdre set. If the event and the clearing write fall in the same cycle, the flag stays set.
- R4: A tx_idle_evt pulse sets tc at the next clock. tc is cleared by the same status-read-then-data-write sequence, and the event wins over the clear in the same cycle.
- R5: An rx_char_evt pulse sets rdrf. If rdrf was clear, or is being cleared in that cycle, rx_byte is loaded into rx_data. An armed data read clears rdrf.
- R6: While the idle machine is in HUNT, an idle line with wake-up off sets the idle flag. An armed data read clears it. After that it stays clear until rx_line_idle has been 0 for at least one cycle.
- R7: While rx_wake is 1, the idle flag cannot become set.
- R8: A character that arrives while rdrf is set and not being cleared sets ovr, and rx_data keeps the earlier character. An armed data read clears ovr, and a new overrun in the same cycle wins.
- R9: The noise and ferr flags are loaded from rx_noise and rx_frame with every character that is accepted. Otherwise an armed data read clears them.
- R10: A status read arms exactly the flags it sees set. A data access clears only armed flags, so a flag that sets after the status read survives the access. A data write disarms the transmit flags and a data read disarms the receive flags.
- R11: A status write changes no flag and no arm bit.
- R12: irq_tx = tdre | tc, and irq_rx = rdrf | idle | ovr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe (no effect) |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| tx_empty_evt | input | 1 | Transmit buffer emptied pulse |
| tx_idle_evt | input | 1 | Transmitter went idle pulse |
| rx_char_evt | input | 1 | Character received pulse |
| rx_byte | input | DATA_W | Received character |
| rx_noise | input | 1 | Noise seen on this character |
| rx_frame | input | 1 | Framing error on this character |
| rx_line_idle | input | 1 | Receive line currently idle |
| rx_wake | input | 1 | Receiver wake-up control bit |
| status_o | output | 8 | Status byte |
| rx_data | output | DATA_W | Held received character |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench goes after flags that set between the status read and the data access. A design that clears every flag on the access, instead of only the armed ones, loses those flags. It checks characters that arrive while rdrf is set: a design that overwrites the held byte, or one that fails to raise overrun, disagrees with the model on rx_data or on bit 3. It holds the line idle after an idle clear and toggles wake-up. A design that sets the idle flag again without an active phase, or that ignores wake-up, shows bit 4 set too early. Randomized cycles also put set events and clears in the same cycle, which exposes a wrong priority between them.

// File: rtl/uflag_pkg.sv
package uflag_pkg;
    localparam int unsigned STAT_W  = 8;
    localparam int unsigned B_TDRE  = 7;
    localparam int unsigned B_TC    = 6;
    localparam int unsigned B_RDRF  = 5;
    localparam int unsigned B_IDLE  = 4;
    localparam int unsigned B_OVR   = 3;
    localparam int unsigned B_NOISE = 2;
    localparam int unsigned B_FERR  = 1;

    localparam logic [STAT_W-1:0] TX_MASK = (8'd1 << B_TDRE) | (8'd1 << B_TC);
    localparam logic [STAT_W-1:0] RX_MASK = (8'd1 << B_RDRF) | (8'd1 << B_IDLE) |
                                            (8'd1 << B_OVR)  | (8'd1 << B_NOISE) |
                                            (8'd1 << B_FERR);

    typedef enum logic [1:0] {
        IDS_HUNT = 2'd0,
        IDS_SET  = 2'd1,
        IDS_WAIT = 2'd2
    } idle_state_t;
endpackage

// File: rtl/uflag_arm.sv
module uflag_arm
    import uflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] arm_q
);
    logic [STAT_W-1:0] keep_mask;
    logic [STAT_W-1:0] arm_d;

    always_comb begin
        keep_mask = '1;
        if (data_wr) keep_mask = keep_mask & ~TX_MASK;
        if (data_rd) keep_mask = keep_mask & ~RX_MASK;
        arm_d = arm_q & keep_mask;
        if (stat_rd) arm_d = arm_d | status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= arm_d;
    end

    // R10: arm bits only appear for flags the status read saw
    a_r10_arm_from_seen: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((arm_q & ~$past(arm_q)) == '0));
endmodule

// File: rtl/uflag_tx.sv
module uflag_tx (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_empty,
    input  logic evt_idle,
    input  logic clr_tdre,
    input  logic clr_tc,
    output logic tdre,
    output logic tc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdre <= 1'b1;
            tc   <= 1'b1;
        end else begin
            tdre <= (tdre & ~clr_tdre) | evt_empty;
            tc   <= (tc & ~clr_tc) | evt_idle;
        end
    end

    // R4: tc can only rise on a transmitter idle event
    a_r4_tc_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc && !evt_idle) |=> !tc);
    // R3: tdre can only rise on a buffer empty event
    a_r3_tdre_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdre && !evt_empty) |=> !tdre);
endmodule

// File: rtl/uflag_rx.sv
module uflag_rx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_evt,
    input  logic [DATA_W-1:0] char_byte,
    input  logic              char_noise,
    input  logic              char_frame,
    input  logic              clr_rdrf,
    input  logic              clr_ovr,
    input  logic              clr_noise,
    input  logic              clr_ferr,
    output logic              rdrf,
    output logic              ovr,
    output logic              noise,
    output logic              ferr,
    output logic [DATA_W-1:0] data_q
);
    logic accept;
    logic lost;

    always_comb begin
        accept = char_evt & (~rdrf | clr_rdrf);
        lost   = char_evt & ~accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdrf   <= 1'b0;
            ovr    <= 1'b0;
            noise  <= 1'b0;
            ferr   <= 1'b0;
            data_q <= '0;
        end else begin
            rdrf <= (rdrf & ~clr_rdrf) | accept;
            ovr  <= (ovr & ~clr_ovr) | lost;
            if (accept) begin
                data_q <= char_byte;
                noise  <= char_noise;
                ferr   <= char_frame;
            end else begin
                noise  <= noise & ~clr_noise;
                ferr   <= ferr & ~clr_ferr;
            end
        end
    end

    // R5: a received character always leaves rdrf set
    a_r5_char_sets_rdrf: assert property (@(posedge clk) disable iff (!rst_n)
        char_evt |=> rdrf);
    // R8: overrun keeps the earlier character and raises ovr
    a_r8_hold_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (char_evt && rdrf && !clr_rdrf) |=> ($stable(data_q) && ovr));
endmodule

// File: rtl/uflag_idle.sv
module uflag_idle
    import uflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    input  logic wake,
    input  logic clr_req,
    output logic flag
);
    idle_state_t state_q;
    idle_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDS_HUNT: if (line_idle && !wake) state_d = IDS_SET;
            IDS_SET:  if (clr_req)            state_d = IDS_WAIT;
            IDS_WAIT: if (!line_idle)         state_d = IDS_HUNT;
            default:                          state_d = IDS_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDS_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == IDS_SET);
    end

    // R6: no new idle flag while waiting for line activity
    a_r6_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDS_WAIT && line_idle) |=> !flag);
    // R7: wake-up bit suppresses setting
    a_r7_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && wake) |=> !flag);
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uflag_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              tx_empty_evt,
    input  logic              tx_idle_evt,
    input  logic              rx_char_evt,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_noise,
    input  logic              rx_frame,
    input  logic              rx_line_idle,
    input  logic              rx_wake,
    output logic [7:0]        status_o,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic [STAT_W-1:0] arm_q;
    logic tdre, tc, rdrf, idle, ovr, noise, ferr;
    logic [STAT_W-1:0] wr_clr;
    logic [STAT_W-1:0] rd_clr;

    always_comb begin
        wr_clr = data_wr ? (arm_q & TX_MASK) : '0;
        rd_clr = data_rd ? (arm_q & RX_MASK) : '0;
    end

    uflag_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .status  (status_o),
        .arm_q   (arm_q)
    );

    uflag_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_empty (tx_empty_evt),
        .evt_idle  (tx_idle_evt),
        .clr_tdre  (wr_clr[B_TDRE]),
        .clr_tc    (wr_clr[B_TC]),
        .tdre      (tdre),
        .tc        (tc)
    );

    uflag_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_evt   (rx_char_evt),
        .char_byte  (rx_byte),
        .char_noise (rx_noise),
        .char_frame (rx_frame),
        .clr_rdrf   (rd_clr[B_RDRF]),
        .clr_ovr    (rd_clr[B_OVR]),
        .clr_noise  (rd_clr[B_NOISE]),
        .clr_ferr   (rd_clr[B_FERR]),
        .rdrf       (rdrf),
        .ovr        (ovr),
        .noise      (noise),
        .ferr       (ferr),
        .data_q     (rx_data)
    );

    uflag_idle u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_idle (rx_line_idle),
        .wake      (rx_wake),
        .clr_req   (rd_clr[B_IDLE]),
        .flag      (idle)
    );

    always_comb begin
        status_o = {tdre, tc, rdrf, idle, ovr, noise, ferr, 1'b0};
        irq_tx   = tdre | tc;
        irq_rx   = rdrf | idle | ovr;
    end

    // R3: armed data write with no new event clears tdre
    a_r3_tdre_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q[B_TDRE] && data_wr && !tx_empty_evt) |=> !status_o[B_TDRE]);
    // R10: an unarmed flag survives the data access
    a_r10_unarmed_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_TDRE] && !arm_q[B_TDRE] && data_wr) |=> status_o[B_TDRE]);
    // R11: a lone status write leaves the arm state alone
    a_r11_stat_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_rd && !data_wr && !data_rd) |=> (arm_q == $past(arm_q)));
endmodule

// File: tb/uart_flag_ctrl_tb_top.sv
module uart_flag_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_rd = 0, stat_wr = 0, data_rd = 0, data_wr = 0;
    logic tx_empty_evt = 0, tx_idle_evt = 0, rx_char_evt = 0;
    logic [DW-1:0] rx_byte = '0;
    logic rx_noise = 0, rx_frame = 0, rx_line_idle = 0, rx_wake = 0;
    logic [7:0] status_o;
    logic [DW-1:0] rx_data;
    logic irq_tx, irq_rx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    logic m_tdre, m_tc, m_rdrf, m_idle, m_ovr, m_nf, m_fe;
    logic [7:0] m_arm;
    logic [DW-1:0] m_data;
    int m_ist; // 0 hunt, 1 set, 2 wait

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_flag_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .data_rd(data_rd), .data_wr(data_wr), .tx_empty_evt(tx_empty_evt),
        .tx_idle_evt(tx_idle_evt), .rx_char_evt(rx_char_evt), .rx_byte(rx_byte),
        .rx_noise(rx_noise), .rx_frame(rx_frame), .rx_line_idle(rx_line_idle),
        .rx_wake(rx_wake), .status_o(status_o), .rx_data(rx_data),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    function automatic logic [7:0] m_status();
        return {m_tdre, m_tc, m_rdrf, m_idle, m_ovr, m_nf, m_fe, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 bit0", {31'd0, status_o[0]}, 32'd0);
        chk("R3 tdre", {31'd0, status_o[7]}, {31'd0, m_tdre});
        chk("R4 tc", {31'd0, status_o[6]}, {31'd0, m_tc});
        chk("R5 rdrf", {31'd0, status_o[5]}, {31'd0, m_rdrf});
        chk("R6 idle", {31'd0, status_o[4]}, {31'd0, m_idle});
        chk("R8 ovr", {31'd0, status_o[3]}, {31'd0, m_ovr});
        chk("R9 noise/ferr", {30'd0, status_o[2:1]}, {30'd0, m_nf, m_fe});
        chk("R8 rx_data", {24'd0, rx_data}, {24'd0, m_data});
        chk("R12 irqs", {30'd0, irq_tx, irq_rx},
            {30'd0, m_tdre | m_tc, m_rdrf | m_idle | m_ovr});
    endtask

    task automatic model_reset();
        m_tdre = 1; m_tc = 1; m_rdrf = 0; m_idle = 0; m_ovr = 0; m_nf = 0; m_fe = 0;
        m_arm = '0; m_data = '0; m_ist = 0;
    endtask

    // one clock: model next state from current inputs, then compare
    task automatic tick();
        logic [7:0] st, na;
        logic wc7, wc6, rc5, rc4, rc3, rc2, rc1, acc, lost;
        int ni;
        st  = m_status();
        wc7 = data_wr & m_arm[7]; wc6 = data_wr & m_arm[6];
        rc5 = data_rd & m_arm[5]; rc4 = data_rd & m_arm[4];
        rc3 = data_rd & m_arm[3]; rc2 = data_rd & m_arm[2]; rc1 = data_rd & m_arm[1];
        na = m_arm;
        if (data_wr) na = na & 8'h3F;
        if (data_rd) na = na & 8'hC1;
        if (stat_rd) na = na | st;
        acc  = rx_char_evt & (~m_rdrf | rc5);
        lost = rx_char_evt & ~acc;
        ni = m_ist;
        case (m_ist)
            0: if (rx_line_idle && !rx_wake) ni = 1;
            1: if (rc4) ni = 2;
            default: if (!rx_line_idle) ni = 0;
        endcase
        @(posedge clk);
        #1;
        m_tdre = (m_tdre & ~wc7) | tx_empty_evt;
        m_tc   = (m_tc & ~wc6) | tx_idle_evt;
        m_rdrf = (m_rdrf & ~rc5) | acc;
        m_ovr  = (m_ovr & ~rc3) | lost;
        if (acc) begin
            m_data = rx_byte; m_nf = rx_noise; m_fe = rx_frame;
        end else begin
            m_nf = m_nf & ~rc2; m_fe = m_fe & ~rc1;
        end
        m_arm = na;
        m_ist = ni;
        m_idle = (ni == 1);
        @(negedge clk);
        compare_all();
        stat_rd = 0; stat_wr = 0; data_rd = 0; data_wr = 0;
        tx_empty_evt = 0; tx_idle_evt = 0; rx_char_evt = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R2 reset status", {24'd0, status_o}, 32'h0000_00C0);
        chk("R2 reset irq", {30'd0, irq_tx, irq_rx}, 32'd2);
        chk("R2 reset data", {24'd0, rx_data}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R10: write without a prior status read leaves tdre/tc set
        data_wr = 1; tick();
        chk("R10 unarmed write keeps tx flags", {30'd0, status_o[7:6]}, 32'd3);
        // R3/R4: read then write clears both
        stat_rd = 1; tick();
        data_wr = 1; tick();
        chk("R3 tdre cleared", {31'd0, status_o[7]}, 32'd0);
        chk("R4 tc cleared", {31'd0, status_o[6]}, 32'd0);
        // R10: status read sees clear, flag then sets, write must not clear it
        stat_rd = 1; tick();
        tx_empty_evt = 1; tick();
        data_wr = 1; tick();
        chk("R10 late flag survives", {31'd0, status_o[7]}, 32'd1);
        // R11: status write does not arm or clear
        stat_wr = 1; tick();
        data_wr = 1; tick();
        chk("R11 stat_wr inert", {31'd0, status_o[7]}, 32'd1);
        // R5/R8/R9: two characters, second overruns
        rx_byte = 8'hA5; rx_noise = 1; rx_frame = 0; rx_char_evt = 1; tick();
        rx_byte = 8'h3C; rx_noise = 0; rx_frame = 1; rx_char_evt = 1; tick();
        chk("R8 earlier byte kept", {24'd0, rx_data}, 32'hA5);
        chk("R8 overrun set", {31'd0, status_o[3]}, 32'd1);
        chk("R9 flags of kept char", {30'd0, status_o[2:1]}, 32'd2);
        stat_rd = 1; tick();
        data_rd = 1; tick();
        chk("R5 rdrf cleared", {31'd0, status_o[5]}, 32'd0);
        chk("R8 ovr cleared", {31'd0, status_o[3]}, 32'd0);
        // R6: idle set, clear, stays clear while line idle
        rx_line_idle = 1; tick();
        chk("R6 idle set", {31'd0, status_o[4]}, 32'd1);
        stat_rd = 1; tick();
        data_rd = 1; tick();
        repeat (4) tick();
        chk("R6 idle stays clear", {31'd0, status_o[4]}, 32'd0);
        rx_line_idle = 0; tick();
        rx_line_idle = 1; tick();
        chk("R6 idle set after activity", {31'd0, status_o[4]}, 32'd1);
        // R7: wake-up suppresses
        stat_rd = 1; tick();
        data_rd = 1; tick();
        rx_line_idle = 0; tick();
        rx_wake = 1; rx_line_idle = 1; repeat (3) tick();
        chk("R7 wake suppresses idle", {31'd0, status_o[4]}, 32'd0);
        rx_wake = 0; tick();
        chk("R7 idle after wake off", {31'd0, status_o[4]}, 32'd1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            stat_rd      = ($urandom_range(0, 3) == 0);
            stat_wr      = ($urandom_range(0, 7) == 0);
            data_rd      = ($urandom_range(0, 4) == 0);
            data_wr      = ($urandom_range(0, 4) == 0);
            tx_empty_evt = ($urandom_range(0, 5) == 0);
            tx_idle_evt  = ($urandom_range(0, 5) == 0);
            rx_char_evt  = ($urandom_range(0, 4) == 0);
            rx_byte      = DW'($urandom);
            rx_noise     = $urandom_range(0, 1) == 1;
            rx_frame     = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 7) == 0) rx_line_idle = ~rx_line_idle;
            if ($urandom_range(0, 15) == 0) rx_wake = ~rx_wake;
            tick();
        end
        finish_run();
    end
endmodule